// File: doc/BRIEF.md
# I2C master bit timer

This block produces the master-side line timing of an I2C controller. An 8-bit divider code selects a multiplier, a group of fixed offsets and a tap position. From these the block derives four counts: the SCL half period, the delay between the SCL fall and the SDA update, the START hold, and the STOP setup. A controller above it issues single-cycle commands: START, a bit slot carrying a data value, or STOP. The block replies with a one-cycle completion pulse and, for each bit slot, the SDA level it saw when SCL fell.

Both lines are open drain. The block only exposes a drive-low request per line, and the pads are read back through a synchroniser of `SYNC_STAGES` flip-flops. A high phase of SCL only counts clocks while the sampled SCL is actually high. A slave that stretches the clock, or another master that holds SCL low, therefore delays the next falling edge. Even when nothing obstructs the line, each high phase is `SYNC_STAGES` clocks longer than the nominal half period.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset both drive-low outputs are 0 (lines released) and `done` is 0.
- R2: For divider code c, define MUL, g, i, s2t, t2t, st and dt as follows. MUL is 1, 2 or 4 when c[7:6] is 0, 1 or 2–3. g = c[5:3] and i = c[2:0]. s2t = 4+2g, t2t = 1+g, st = 5+i and dt = 1+floor(i/2). The half period is H = MUL·(s2t+(st−1)·t2t+2), so the SCL period is 2H; codes 0x00–0x05 give periods 20, 22, 24, 26, 28 and 30. In a bit or STOP slot, SCL stays driven low for exactly H clocks after the clock edge that accepts the command, provided SCL has been low for at least `SYNC_STAGES` clocks before that edge.
- R3: In a bit slot, SDA takes its new level D = MUL·(s2t+(dt−1)·t2t+3) clocks after the accepting edge; codes 0x00–0x05 give 7, 7, 8, 8, 9 and 9. A data value of 1 releases SDA and a value of 0 drives it low. SDA does not change while SCL is released during a bit slot.
- R4: Once the SCL pad is actually high, the block keeps SCL released for exactly H + `SYNC_STAGES` clocks before driving it low again. While the sampled SCL is held low by another device, the block does not drive SCL low.
- R5: START is accepted only when the block is idle. SDA is driven low at the accepting edge, and SCL is driven low MUL·(6+2g+(st−1)·t2t) clocks later.
- R6: STOP drives SDA low D clocks into its low phase and releases SCL after H clocks. It releases SDA P + `SYNC_STAGES` clocks after the SCL pad goes high, where P = MUL·(7+2g+(st−1)·t2t); codes 0x00–0x05 give P from 11 to 16. Both lines then stay released and the block is idle.
- R7: `done` is a one-cycle pulse at the end of each accepted command. At the end of a bit slot, `rx_bit` holds the SDA line level sampled at the SCL fall.
- R8: Bit and STOP commands are accepted only when SCL is held low after a START or a bit slot. A command arriving in any other state, including START while SCL is held, has no effect on either line and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 8 | Divider code; hold stable while a command runs |
| cmd_start | input | 1 | Single-cycle START request |
| cmd_bit | input | 1 | Single-cycle bit slot request |
| cmd_stop | input | 1 | Single-cycle STOP request (wins over cmd_bit) |
| cmd_data | input | 1 | Data value for a bit slot |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | Command completion pulse |
| rx_bit | output | 1 | SDA level sampled at the end of the last bit slot |

## Verification
The hardest case to reach is a high phase stretched by another device. The counter must freeze, and it must then count a full H + `SYNC_STAGES` clocks from the moment the pad really rises. The bench reaches this by pulling its model of the SCL wire low before the block releases SCL, holding it for a number of clocks, and then letting go just after a clock edge. It then counts how many cycles the wire stays high. A slave acknowledge is modelled the same way on SDA, so that `rx_bit` differs from the value the block itself drove.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

   // Width of every timing count; the largest count (code 0xBF) is 436.
   localparam int BT_TW = 10;

   typedef struct packed {
      logic [BT_TW-1:0] half;       // SCL half period
      logic [BT_TW-1:0] sda_hold;   // SDA update point inside the low phase
      logic [BT_TW-1:0] start_hold; // SDA fall to SCL fall in START
      logic [BT_TW-1:0] stop_hold;  // sampled SCL high to SDA release in STOP
   } bt_timing_t;

   typedef enum logic [2:0] {
      BT_IDLE  = 3'd0,
      BT_START = 3'd1,
      BT_HELD  = 3'd2,
      BT_LOW   = 3'd3,
      BT_HIGH  = 3'd4
   } bt_state_t;

   function automatic int bt_mul(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 2;
         default: return 4;
      endcase
   endfunction

   function automatic bt_timing_t bt_decode(input logic [7:0] code);
      bt_timing_t r;
      int mul, grp, tap, scl2tap, tap2tap, scl2start, scl2stop, scl_tap, sda_tap;
      mul       = bt_mul(code[7:6]);
      grp       = int'(code[5:3]);
      tap       = int'(code[2:0]);
      scl2tap   = 4 + 2 * grp;
      tap2tap   = 1 + grp;
      scl2start = 6 + 2 * grp;
      scl2stop  = 7 + 2 * grp;
      scl_tap   = 5 + tap;
      sda_tap   = 1 + tap / 2;
      r.half       = BT_TW'(mul * (scl2tap + (scl_tap - 1) * tap2tap + 2));
      r.sda_hold   = BT_TW'(mul * (scl2tap + (sda_tap - 1) * tap2tap + 3));
      r.start_hold = BT_TW'(mul * (scl2start + (scl_tap - 1) * tap2tap));
      r.stop_hold  = BT_TW'(mul * (scl2stop + (scl_tap - 1) * tap2tap));
      return r;
   endfunction

endpackage

// File: rtl/i2c_bt_calc.sv
module i2c_bt_calc
   import i2c_bt_pkg::*;
#(
   parameter int CODE_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output bt_timing_t        tm
);

   if (CODE_W != 8) begin : g_bad_code_w
      $error("i2c_bt_calc: CODE_W must be 8");
   end
   if (BT_TW < 9) begin : g_bad_tw
      $error("i2c_bt_calc: BT_TW too narrow for the largest count");
   end

   bt_timing_t tm_c;
   assign tm_c = bt_decode(code);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tm <= bt_decode('0);
         else        tm <= tm_c;
      end
   end else begin : g_comb
      assign tm = tm_c;
   end

endmodule

// File: rtl/i2c_bt_sync.sv
module i2c_bt_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_bt_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '1;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '1;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_bt_fsm.sv
module i2c_bt_fsm
   import i2c_bt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  bt_timing_t tm,
   input  logic       cmd_start,
   input  logic       cmd_bit,
   input  logic       cmd_stop,
   input  logic       cmd_data,
   input  logic       scl_s,
   input  logic       sda_s,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       done,
   output logic       rx_bit,
   output bt_state_t  state
);

   logic [BT_TW-1:0] cnt;
   logic [BT_TW-1:0] cnt_nx;
   logic             is_stop;
   logic             data_q;
   logic             line_ok;

   assign cnt_nx  = cnt + 1'b1;
   // the sampled SCL level must match what is being driven before time advances
   assign line_ok = (scl_s == ~scl_oe);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= BT_IDLE;
         cnt     <= '0;
         scl_oe  <= 1'b0;
         sda_oe  <= 1'b0;
         done    <= 1'b0;
         rx_bit  <= 1'b0;
         is_stop <= 1'b0;
         data_q  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            BT_IDLE: begin
               if (cmd_start) begin
                  sda_oe <= 1'b1;
                  cnt    <= '0;
                  state  <= BT_START;
               end
            end
            BT_START: begin
               if (cnt_nx == tm.start_hold) begin
                  scl_oe <= 1'b1;
                  done   <= 1'b1;
                  cnt    <= '0;
                  state  <= BT_HELD;
               end else begin
                  cnt <= cnt_nx;
               end
            end
            BT_HELD: begin
               if (cmd_stop || cmd_bit) begin
                  is_stop <= cmd_stop;
                  data_q  <= cmd_data;
                  cnt     <= '0;
                  state   <= BT_LOW;
               end
            end
            BT_LOW: begin
               if (line_ok) begin
                  cnt <= cnt_nx;
                  if (cnt_nx == tm.sda_hold) sda_oe <= is_stop | ~data_q;
                  if (cnt_nx == tm.half) begin
                     scl_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= BT_HIGH;
                  end
               end
            end
            BT_HIGH: begin
               if (line_ok) begin
                  cnt <= cnt_nx;
                  if (is_stop && cnt_nx == tm.stop_hold) begin
                     sda_oe <= 1'b0;
                     done   <= 1'b1;
                     cnt    <= '0;
                     state  <= BT_IDLE;
                  end else if (!is_stop && cnt_nx == tm.half) begin
                     scl_oe <= 1'b1;
                     rx_bit <= sda_s;
                     done   <= 1'b1;
                     cnt    <= '0;
                     state  <= BT_HELD;
                  end
               end
            end
            default: state <= BT_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
   import i2c_bt_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_TIMING  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] div_code,
   input  logic              cmd_start,
   input  logic              cmd_bit,
   input  logic              cmd_stop,
   input  logic              cmd_data,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   output logic              done,
   output logic              rx_bit
);

   localparam int LINES = 2;

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("i2c_bit_timer: SYNC_STAGES must be 2 to 4");
   end

   bt_timing_t       timing;
   bt_state_t        fsm_state;
   logic [LINES-1:0] pad_raw;
   logic [LINES-1:0] pad_sync;
   logic             scl_sync;
   logic             sda_sync;

   i2c_bt_calc #(
      .CODE_W  (CODE_W),
      .REG_OUT (REG_TIMING)
   ) u_calc (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (div_code),
      .tm    (timing)
   );

   assign pad_raw = {sda_in, scl_in};

   i2c_bt_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (LINES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_raw),
      .q     (pad_sync)
   );

   assign scl_sync = pad_sync[0];
   assign sda_sync = pad_sync[1];

   i2c_bt_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tm        (timing),
      .cmd_start (cmd_start),
      .cmd_bit   (cmd_bit),
      .cmd_stop  (cmd_stop),
      .cmd_data  (cmd_data),
      .scl_s     (scl_sync),
      .sda_s     (sda_sync),
      .scl_oe    (scl_drive_low),
      .sda_oe    (sda_drive_low),
      .done      (done),
      .rx_bit    (rx_bit),
      .state     (fsm_state)
   );

endmodule

// File: rtl/i2c_bt_chk.sv
module i2c_bt_chk
   import i2c_bt_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      cmd_start,
   input logic      cmd_bit,
   input logic      cmd_stop,
   input logic      scl_drive_low,
   input logic      sda_drive_low,
   input logic      done,
   input logic      scl_s,
   input bt_state_t st
);

   p_reset_release_r1: assert property (@(posedge clk)
      !rst_n |=> (!scl_drive_low && !sda_drive_low && !done));

   p_sda_still_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BT_HIGH && $past(st) == BT_HIGH) |-> $stable(sda_drive_low));

   p_stretch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BT_HIGH && !scl_s) |=> !scl_drive_low);

   p_start_sda_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BT_IDLE && cmd_start) |=> (sda_drive_low && !scl_drive_low));

   p_stop_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_drive_low) && !scl_drive_low) |-> st == BT_IDLE);

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_held_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BT_HELD && !cmd_bit && !cmd_stop) |=> (st == BT_HELD && scl_drive_low && !done));

endmodule

bind i2c_bit_timer i2c_bt_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_start     (cmd_start),
   .cmd_bit       (cmd_bit),
   .cmd_stop      (cmd_stop),
   .scl_drive_low (scl_drive_low),
   .sda_drive_low (sda_drive_low),
   .done          (done),
   .scl_s         (scl_sync),
   .st            (fsm_state)
);

// File: tb/tb_i2c_bit_timer.sv
module tb_i2c_bit_timer;

   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] div_code;
   logic       cmd_start, cmd_bit, cmd_stop, cmd_data;
   logic       ext_scl_low, ext_sda_low;
   logic       scl_drive_low, sda_drive_low, done, rx_bit;
   logic       scl_line, sda_line;

   always #5 clk = ~clk;

   // wired-AND pad model
   assign scl_line = ~scl_drive_low & ~ext_scl_low;
   assign sda_line = ~sda_drive_low & ~ext_sda_low;

   i2c_bit_timer #(.SYNC_STAGES(SYNC)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .div_code      (div_code),
      .cmd_start     (cmd_start),
      .cmd_bit       (cmd_bit),
      .cmd_stop      (cmd_stop),
      .cmd_data      (cmd_data),
      .scl_in        (scl_line),
      .sda_in        (sda_line),
      .scl_drive_low (scl_drive_low),
      .sda_drive_low (sda_drive_low),
      .done          (done),
      .rx_bit        (rx_bit)
   );

   int total = 0;
   int bad   = 0;

   typedef struct {
      bit is_bit;
      bit rx;
   } exp_item_t;

   exp_item_t sb_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // expected counts from the R2/R3/R5/R6 formulas
   task automatic exp_counts(input logic [7:0] c, output int h, output int dh,
                             output int sh, output int ph);
      int m, g, i, t2t, sct, sdt;
      m   = (c[7:6] == 2'd0) ? 1 : (c[7:6] == 2'd1) ? 2 : 4;
      g   = int'(c[5:3]);
      i   = int'(c[2:0]);
      t2t = 1 + g;
      sct = 5 + i;
      sdt = 1 + i / 2;
      h   = m * ((4 + 2 * g) + (sct - 1) * t2t + 2);
      dh  = m * ((4 + 2 * g) + (sdt - 1) * t2t + 3);
      sh  = m * ((6 + 2 * g) + (sct - 1) * t2t);
      ph  = m * ((7 + 2 * g) + (sct - 1) * t2t);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R8", "done with no command pending", 1, 0);
         end else begin
            exp_item_t e;
            e = sb_q.pop_front();
            if (e.is_bit) check(rx_bit == e.rx, "R7", "rx_bit", int'(rx_bit), int'(e.rx));
            else          check(1'b1, "R7", "done pulse", 1, 1);
         end
      end
   end

   task automatic pulse(input int which, input bit data);
      @(posedge clk); #1;
      cmd_data = data;
      case (which)
         0:       cmd_start = 1'b1;
         1:       cmd_bit   = 1'b1;
         default: cmd_stop  = 1'b1;
      endcase
      @(posedge clk); #1;
      cmd_start = 1'b0; cmd_bit = 1'b0; cmd_stop = 1'b0;
   endtask

   task automatic gap();
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic do_start(input int sh);
      int n;
      bit sda_first;
      sb_q.push_back('{is_bit: 1'b0, rx: 1'b0});
      pulse(0, 1'b0);
      n = 0;
      sda_first = 1'b1;
      forever begin
         @(negedge clk);
         if (n == 0) sda_first = sda_line;
         if (!scl_line) break;
         n++;
      end
      check(sda_first == 1'b0, "R5", "SDA low right after START", int'(sda_first), 0);
      check(n == sh, "R5", "START hold clocks", n, sh);
      gap();
   endtask

   task automatic do_bit(input int h, input int dh, input bit v, input bit ack, input int stretch);
      int  j, dseen, hi;
      bit  prev, want, sda_moved;
      prev = sda_line;
      want = v & ~ack;
      if (ack) ext_sda_low = 1'b1;
      if (stretch > 0) ext_scl_low = 1'b1;
      sb_q.push_back('{is_bit: 1'b1, rx: want});
      pulse(1, v);
      j = 0;
      dseen = -1;
      forever begin
         @(negedge clk);
         j++;
         if (dseen < 0 && sda_line != prev) dseen = j - 1;
         if (!scl_drive_low) break;
      end
      check(j - 1 == h, "R2", "bit low phase clocks", j - 1, h);
      if (!ack && prev != v) check(dseen == dh, "R3", "SDA update delay", dseen, dh);
      check(sda_line == want, "R3", "SDA level in bit slot", int'(sda_line), int'(want));
      if (stretch > 0) begin
         hi = 0;
         repeat (stretch) @(negedge clk);
         check(scl_drive_low == 1'b0, "R4", "no drive while line held low", int'(scl_drive_low), 0);
         @(posedge clk); #1;
         ext_scl_low = 1'b0;
      end else begin
         hi = 1;
      end
      sda_moved = 1'b0;
      forever begin
         @(negedge clk);
         if (!scl_line) break;
         if (sda_line != want) sda_moved = 1'b1;
         hi++;
      end
      check(hi == h + SYNC, "R4", "SCL high clocks", hi, h + SYNC);
      check(sda_moved == 1'b0, "R3", "SDA moved while SCL high", int'(sda_moved), 0);
      @(posedge clk); #1;
      ext_sda_low = 1'b0;
      gap();
   endtask

   task automatic do_stop(input int h, input int dh, input int ph);
      int j, dseen, hi;
      bit prev;
      prev = sda_line;
      sb_q.push_back('{is_bit: 1'b0, rx: 1'b0});
      pulse(2, 1'b0);
      j = 0;
      dseen = -1;
      forever begin
         @(negedge clk);
         j++;
         if (dseen < 0 && sda_line != prev) dseen = j - 1;
         if (!scl_drive_low) break;
      end
      check(j - 1 == h, "R6", "STOP low phase clocks", j - 1, h);
      if (prev) check(dseen == dh, "R6", "SDA low delay in STOP", dseen, dh);
      hi = 1;
      forever begin
         @(negedge clk);
         if (sda_line) break;
         hi++;
      end
      check(hi == ph + SYNC, "R6", "STOP setup clocks", hi, ph + SYNC);
      repeat (6) @(negedge clk);
      check(scl_line && sda_line, "R6", "lines idle after STOP",
            int'({scl_line, sda_line}), 3);
      gap();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] codes [8];
      int h, dh, sh, ph;
      codes = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h42, 8'h89};
      rst_n = 1'b0;
      div_code = 8'h00;
      cmd_start = 1'b0; cmd_bit = 1'b0; cmd_stop = 1'b0; cmd_data = 1'b0;
      ext_scl_low = 1'b0; ext_sda_low = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!scl_drive_low && !sda_drive_low && !done, "R1", "reset state",
            int'({scl_drive_low, sda_drive_low, done}), 0);
      #1 rst_n = 1'b1;
      gap();

      // R8: bit and stop in idle are ignored
      pulse(1, 1'b0);
      pulse(2, 1'b0);
      repeat (30) @(negedge clk);
      check(!scl_drive_low && !sda_drive_low, "R8", "idle ignores bit/stop",
            int'({scl_drive_low, sda_drive_low}), 0);

      foreach (codes[k]) begin
         div_code = codes[k];
         exp_counts(codes[k], h, dh, sh, ph);
         gap();
         do_start(sh);
         if (k == 0) begin
            // R8: START while SCL held is ignored
            pulse(0, 1'b0);
            repeat (30) @(negedge clk);
            check(scl_drive_low && sda_drive_low, "R8", "held ignores START",
                  int'({scl_drive_low, sda_drive_low}), 3);
            gap();
         end
         do_bit(h, dh, 1'b0, 1'b0, 0);
         do_bit(h, dh, 1'b1, 1'b0, 0);
         do_bit(h, dh, 1'b1, 1'b1, 0);
         do_bit(h, dh, 1'b0, 1'b0, (k % 2 == 0) ? 15 : 0);
         do_bit(h, dh, 1'b1, 1'b0, (k == 7) ? 40 : 0);
         do_stop(h, dh, ph);
      end

      repeat (10) @(posedge clk);
      check(sb_q.size() == 0, "R7", "completions outstanding", sb_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule